// File: doc/BRIEF.md
# Vector ternary bitwise logic unit

The unit computes bitwise results over three vector operands (a destination value and two sources). Its main operation treats an 8-bit immediate as a truth table. For every bit position, the three operand bits at that position form a 3-bit index into the immediate, and the selected immediate bit becomes the result bit. The destination value supplies the most significant index bit, so the result is meant to overwrite that destination. One such operation can express any Boolean function of three inputs, including inversion of a single source and constant all-ones.

The unit also has fixed helper operations: AND-NOT, XOR, and lane-wise equality compares that produce all-ones lanes for matching lanes. The operating width is selected per request as a quarter, a half or the whole of `VLEN` (128, 256 or 512 bits at the default). Result bits above the selected width read zero.

A request is accepted on a valid/ready handshake. The result is registered, appears one cycle after acceptance, and is held until the consumer takes it.

Top module: `vtlogic`

## Requirements
- R1: With opcode 0 (ternary), every result bit i equals req_imm[{req_dest[i], req_src1[i], req_src2[i]}], with req_dest as index bit 2 and req_src2 as index bit 0.
- R2: Ternary with immediate 0x55 returns the bitwise inverse of req_src2, whatever req_dest and req_src1 hold.
- R3: Ternary with immediate 0xFF returns all ones within the selected width, whatever the operands hold.
- R4: req_width 0 selects VLEN/4 bits, 1 selects VLEN/2 bits, and 2 or 3 selects all VLEN bits. Result bits at or above the selected width are zero for every opcode.
- R5: Opcode 1 (AND-NOT) returns ~req_src1 & req_src2, bit by bit.
- R6: Opcode 2 (XOR) returns req_src1 ^ req_src2, bit by bit.
- R7: Opcode 3 compares 8-bit lanes and opcode 4 compares 32-bit lanes of req_src1 and req_src2. A lane is all ones when the two lanes are equal and all zeros otherwise, so comparing an operand with itself yields all ones.
- R8: Opcodes 5 to 7 return an all-zero result with rsp_err high. Opcodes 0 to 4 return rsp_err low.
- R9: A request is accepted when req_valid and req_ready are both high. req_ready is high when no response is pending or rsp_ready is high. rsp_valid rises on the clock edge that accepts the request, and rsp_data and rsp_err stay unchanged while rsp_valid is high and rsp_ready is low.
- R10: After reset, rsp_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 3 | Opcode: 0 ternary, 1 AND-NOT, 2 XOR, 3 eq8, 4 eq32 |
| req_width | input | 2 | Width select: 0 quarter, 1 half, 2/3 full |
| req_dest | input | VLEN | Destination value, index bit 2 of the ternary |
| req_src1 | input | VLEN | First source, ternary index bit 1 |
| req_src2 | input | VLEN | Second source, ternary index bit 0 |
| req_imm | input | 8 | Ternary truth table |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | VLEN | Registered result |
| rsp_err | output | 1 | Unsupported opcode in this response |

## Verification
The ternary operation is swept over all 256 immediates. One operand pattern makes the 8 bits of every byte walk the 8 index combinations, so each result byte must equal the immediate. This exposes any swap of the index bit order. Pseudo-random operands at every width show that the truth-table lookup is independent per bit and that the upper bits are cleared. The compares use identical operands and operands that differ in a single byte, which separates the 8-bit and 32-bit lane grouping. A stalled consumer shows that the response is held.

// File: rtl/vtlogic.sv
module vtlogic #(
  parameter int VLEN = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [1:0]      req_width,
  input  logic [VLEN-1:0] req_dest,
  input  logic [VLEN-1:0] req_src1,
  input  logic [VLEN-1:0] req_src2,
  input  logic [7:0]      req_imm,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [VLEN-1:0] rsp_data,
  output logic            rsp_err
);
  localparam int QW = VLEN / 4;
  localparam int HW = VLEN / 2;
  localparam int N8 = VLEN / 8;
  localparam int N32 = VLEN / 32;

  logic [VLEN-1:0] tern, eq8, eq32, res, mask;
  logic            err;
  logic [1:0]      rsp_wd;
  logic            take;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take = req_valid && req_ready;

  genvar i;
  generate
    for (i = 0; i < VLEN; i++) begin : g_bit
      assign tern[i] = req_imm[{req_dest[i], req_src1[i], req_src2[i]}];
    end
    for (i = 0; i < N8; i++) begin : g_l8
      assign eq8[8*i +: 8] = {8{req_src1[8*i +: 8] == req_src2[8*i +: 8]}};
    end
    for (i = 0; i < N32; i++) begin : g_l32
      assign eq32[32*i +: 32] = {32{req_src1[32*i +: 32] == req_src2[32*i +: 32]}};
    end
  endgenerate

  always_comb begin
    err = 1'b0;
    case (req_op)
      3'd0: res = tern;
      3'd1: res = ~req_src1 & req_src2;
      3'd2: res = req_src1 ^ req_src2;
      3'd3: res = eq8;
      3'd4: res = eq32;
      default: begin
        res = '0;
        err = 1'b1;
      end
    endcase
  end

  always_comb begin
    mask = '1;
    if (req_width == 2'd0) mask = {{(VLEN-QW){1'b0}}, {QW{1'b1}}};
    else if (req_width == 2'd1) mask = {{(VLEN-HW){1'b0}}, {HW{1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      rsp_wd    <= 2'd0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= res & mask;
      rsp_err   <= err;
      rsp_wd    <= req_width;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_data == '0);
  p_quarter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_wd == 2'd0 |-> rsp_data[VLEN-1:QW] == '0);
  p_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_wd == 2'd1 |-> rsp_data[VLEN-1:HW] == '0);
endmodule

// File: tb/sim_vtlogic.sv
`timescale 1ns/1ps
module sim_vtlogic;
  localparam int V = 512;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 1;
  logic req_ready, rsp_valid, rsp_err;
  logic [2:0] req_op = 0;
  logic [1:0] req_width = 0;
  logic [V-1:0] req_dest = 0, req_src1 = 0, req_src2 = 0, rsp_data;
  logic [7:0] req_imm = 0;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  vtlogic #(.VLEN(V)) u0 (.*);

  task automatic chk(input string tag, input logic [V-1:0] act, input logic [V-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [V-1:0] wmask(input logic [1:0] w);
    logic [V-1:0] m = '1;
    if (w == 0) m = m >> (3*V/4);
    else if (w == 1) m = m >> (V/2);
    return m;
  endfunction

  function automatic logic [V-1:0] rnd();
    logic [V-1:0] r;
    for (int k = 0; k < V/32; k++) r[32*k +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [V-1:0] model(input logic [2:0] op, input logic [1:0] w,
      input logic [V-1:0] d, a, b, input logic [7:0] imm);
    logic [V-1:0] r = '0;
    case (op)
      0: for (int k = 0; k < V; k++) r[k] = imm[d[k]*4 + a[k]*2 + b[k]];
      1: r = ~a & b;
      2: r = a ^ b;
      3: for (int k = 0; k < V/8; k++) r[8*k +: 8] = (a[8*k +: 8] == b[8*k +: 8]) ? 8'hFF : 8'h00;
      4: for (int k = 0; k < V/32; k++) r[32*k +: 32] = (a[32*k +: 32] == b[32*k +: 32]) ? '1 : '0;
      default: r = '0;
    endcase
    return r & wmask(w);
  endfunction

  task automatic run(input string tag, input logic [2:0] op, input logic [1:0] w,
      input logic [V-1:0] d, a, b, input logic [7:0] imm, output logic [V-1:0] got);
    @(negedge clk);
    req_op = op; req_width = w; req_dest = d; req_src1 = a; req_src2 = b; req_imm = imm;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R9 valid"}, {{(V-1){1'b0}}, rsp_valid}, 1);
    chk({tag, " R8 err"}, {{(V-1){1'b0}}, rsp_err}, (op > 4) ? 1 : 0);
    chk(tag, rsp_data, model(op, w, d, a, b, imm));
    got = rsp_data;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog R9 act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [V-1:0] g, a, b, pd, p1, p2, ones;
    ones = '1;
    repeat (3) @(negedge clk);
    chk("R10 rsp_valid", {{(V-1){1'b0}}, rsp_valid}, 0);
    chk("R10 req_ready", {{(V-1){1'b0}}, req_ready}, 1);
    rst_n = 1;
    for (int k = 0; k < V/8; k++) begin
      pd[8*k +: 8] = 8'hF0; p1[8*k +: 8] = 8'hCC; p2[8*k +: 8] = 8'hAA;
    end
    for (int im = 0; im < 256; im++) begin
      run("R1 walk", 0, 2, pd, p1, p2, im[7:0], g);
      chk("R1 byte=imm", g[7:0], {{(V-8){1'b0}}, im[7:0]});
    end
    for (int n = 0; n < 40; n++) begin
      logic [1:0] w = n[1:0];
      run("R1 rand R4", 0, w, rnd(), rnd(), rnd(), 8'($urandom), g);
    end
    for (int n = 0; n < 8; n++) begin
      b = rnd();
      run("R2 not src2", 0, 2, rnd(), rnd(), b, 8'h55, g);
      chk("R2 inverse", g, ~b);
      run("R3 ones", 0, n[1:0], rnd(), rnd(), rnd(), 8'hFF, g);
      chk("R3 R4 ones", g, wmask(n[1:0]));
    end
    for (int n = 0; n < 12; n++) begin
      logic [1:0] w = n[1:0];
      a = rnd(); b = rnd();
      run("R5 andn", 1, w, rnd(), a, b, 0, g);
      run("R6 xor", 2, w, rnd(), a, b, 0, g);
    end
    for (int n = 0; n < 16; n++) begin
      a = rnd();
      run("R7 eq8 self", 3, 2, 0, a, a, 0, g);
      chk("R7 eq8 ones", g, ones);
      run("R7 eq32 self", 4, 2, 0, a, a, 0, g);
      chk("R7 eq32 ones", g, ones);
      b = a;
      b[8*(n*3 % (V/8)) +: 8] = ~b[8*(n*3 % (V/8)) +: 8];
      run("R7 eq8 diff", 3, 2, 0, a, b, 0, g);
      run("R7 eq32 diff", 4, 2, 0, a, b, 0, g);
      run("R7 R4 eq8 quarter", 3, 0, 0, a, b, 0, g);
    end
    for (int op = 5; op < 8; op++)
      run("R8 bad op", op[2:0], 2, rnd(), rnd(), rnd(), 8'hFF, g);
    @(negedge clk);
    rsp_ready = 0;
    req_op = 2; req_width = 2; req_src1 = rnd(); req_src2 = rnd(); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    g = rsp_data;
    chk("R9 result", g, req_src1 ^ req_src2);
    req_valid = 1; req_src1 = rnd();
    repeat (3) @(negedge clk);
    chk("R9 held valid", {{(V-1){1'b0}}, rsp_valid}, 1);
    chk("R9 not ready", {{(V-1){1'b0}}, req_ready}, 0);
    chk("R9 held data", rsp_data, g);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R9 next taken", rsp_data, req_src1 ^ req_src2);
    @(negedge clk);
    chk("R9 consumed", {{(V-1){1'b0}}, rsp_valid}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule